// File: doc/BRIEF.md
# Four-Channel Serial DAC Command Front End

This block is the digital front end of a four-channel digital-to-analog converter. It takes in 24-bit command words over a three-wire serial port. The port has a serial clock, an active-low frame select and a serial data line. The block keeps two register levels per channel: a data buffer and the DAC register that drives the converter.

Each complete command writes buffers and, according to its two load-mode bits, copies buffers into DAC registers. Separately, a rising edge on the load strobe copies every buffer into its DAC register in the same cycle. A frame that is cut short leaves every register as it was. A port-disable input makes the block deaf to the serial pins. This lets several devices share one serial bus.

All pins are oversampled in a single system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock.

Top module: `qdac_front`

## Requirements
- R1: A frame begins when frame select falls. Data is taken MSB first on each falling serial-clock edge. The frame takes effect on the 24th falling edge if frame select has stayed low throughout. Further falling edges are ignored until frame select rises and falls again.
- R2: A frame during which frame select rises before the 24th falling serial-clock edge is dropped. No buffer, DAC register or reference flag changes.
- R3: Command layout: bits 21..20 are the load mode, bit 19 is the reference-command flag, bits 18..17 select the channel and bits 15..0 are the data. Bits 23, 22 and 16 are ignored. Load mode 01 writes the data into the selected channel's buffer and DAC register.
- R4: Load mode 00 writes only the selected channel's buffer. No DAC register changes.
- R5: A rising edge on the load strobe copies every buffer into its DAC register in one cycle. A channel whose buffer was not rewritten keeps its output.
- R6: Load mode 10 writes the selected buffer, then loads all four DAC registers from their buffers, including the value just written.
- R7: Load mode 11 writes the data into all four buffers and all four DAC registers.
- R8: A command with bit 19 set copies bit 0 into the reference-enable output and leaves every buffer and DAC register unchanged.
- R9: While port disable is high, activity on serial clock, frame select and data has no effect, and a frame in progress is dropped.
- R10: After reset, all DAC registers read zero and reference enable reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, data taken on its falling edge |
| sel_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data, MSB first |
| ldac_i | input | 1 | Load strobe, rising edge updates all channels |
| port_dis_i | input | 1 | High makes the serial port ignored |
| dac_regs_o | output | NCH*DW (64) | DAC registers, channel 0 in the low 16 bits |
| ref_en_o | output | 1 | Internal reference enable flag |

## Verification
Two cases are hardest to reach: an abort that lands after many bits are already shifted, and the interaction of the two register levels. Buffers are not visible at the ports. The stimulus therefore first stages buffers with mode-00 commands and then exposes them through a load-strobe pulse or a mode-10 command. It uses this to show that an aborted frame, a reference command and a disabled-port frame each left the buffers untouched. A behavioural model sees the same two-cycle pin delay and is compared with the outputs on every clock. It also covers a frame that runs extra clocks past the 24th edge.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int FRAME_W = 24;
  localparam int VAL_W   = 16;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    LD_BUF_ONLY = 2'b00,
    LD_SELF     = 2'b01,
    LD_ALL_BUF  = 2'b10,
    LD_BCAST    = 2'b11
  } ld_mode_e;

  typedef struct packed {
    logic [1:0]       pad_hi;
    ld_mode_e         mode;
    logic             ref_cmd;
    logic [1:0]       chan;
    logic             pad_lo;
    logic [VAL_W-1:0] value;
  } cmd_t;

  // bit positions of the synchronized pin bundle
  localparam int PIN_SCLK = 0;
  localparam int PIN_DIN  = 1;
  localparam int PIN_SELN = 2;
  localparam int PIN_LDAC = 3;
  localparam int PIN_DIS  = 4;
  localparam int PIN_W    = 5;
  localparam logic [PIN_W-1:0] PIN_RST = 5'b10100;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
  import qdac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_fall,
  input  logic               sel_fall,
  input  logic               sel_n_s,
  input  logic               din_s,
  input  logic               dis_s,
  output logic               cmd_valid_o,
  output logic [FRAME_W-1:0] cmd_word_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               act_q, act_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-2:0] sh_q, sh_d;
  logic [FRAME_W-1:0] word;

  assign word = {sh_q, din_s};

  always_comb begin
    act_d       = act_q;
    cnt_d       = cnt_q;
    sh_d        = sh_q;
    cmd_valid_o = 1'b0;
    if (dis_s || sel_n_s) begin
      act_d = 1'b0;
      cnt_d = '0;
      sh_d  = '0;
    end else if (sel_fall) begin
      act_d = 1'b1;
      cnt_d = '0;
      sh_d  = '0;
    end else if (act_q && sclk_fall) begin
      if (cnt_q == LAST_BIT) begin
        cmd_valid_o = 1'b1;
        act_d       = 1'b0;
        cnt_d       = '0;
        sh_d        = '0;
      end else begin
        sh_d  = word[FRAME_W-2:0];
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign cmd_word_o = word;
endmodule

// File: rtl/qdac_reg_bank.sv
module qdac_reg_bank
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = VAL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [FRAME_W-1:0] cmd_word,
  input  logic               ldac_rise,
  output logic [NCH*DW-1:0]  dac_o,
  output logic               ref_en_o
);
  cmd_t          cmd;
  logic [DW-1:0] dbuf_q [NCH];
  logic [DW-1:0] dbuf_d [NCH];
  logic [DW-1:0] dac_q  [NCH];
  logic [DW-1:0] dac_d  [NCH];
  logic          ref_q, ref_d;
  logic          upd_en;

  assign cmd    = cmd_t'(cmd_word);
  assign upd_en = cmd_valid | ldac_rise;

  always_comb begin
    dbuf_d = dbuf_q;
    dac_d  = dac_q;
    ref_d  = ref_q;
    if (cmd_valid) begin
      if (cmd.ref_cmd) begin
        ref_d = cmd.value[0];
      end else begin
        unique case (cmd.mode)
          LD_BUF_ONLY: dbuf_d[cmd.chan] = cmd.value;
          LD_SELF: begin
            dbuf_d[cmd.chan] = cmd.value;
            dac_d[cmd.chan]  = cmd.value;
          end
          LD_ALL_BUF: begin
            dbuf_d[cmd.chan] = cmd.value;
            for (int i = 0; i < NCH; i++) dac_d[i] = dbuf_d[i];
          end
          LD_BCAST: begin
            for (int i = 0; i < NCH; i++) begin
              dbuf_d[i] = cmd.value;
              dac_d[i]  = cmd.value;
            end
          end
          default: ;
        endcase
      end
    end
    if (ldac_rise) begin
      for (int i = 0; i < NCH; i++) dac_d[i] = dbuf_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        dbuf_q[i] <= '0;
        dac_q[i]  <= '0;
      end
      ref_q <= 1'b1;
    end else if (upd_en) begin
      dbuf_q <= dbuf_d;
      dac_q  <= dac_d;
      ref_q  <= ref_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign dac_o[g*DW +: DW] = dac_q[g];
  end

  assign ref_en_o = ref_q;
endmodule

// File: rtl/qdac_front.sv
module qdac_front
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = VAL_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sel_n_i,
  input  logic              sdi_i,
  input  logic              ldac_i,
  input  logic              port_dis_i,
  output logic [NCH*DW-1:0] dac_regs_o,
  output logic              ref_en_o
);
  logic [PIN_W-1:0]   pins_raw, pins_s, pins_q;
  logic               sclk_fall, sel_fall, ldac_rise, dis_s;
  logic               cmd_valid;
  logic [FRAME_W-1:0] cmd_word;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCLK] = sclk_i;
    pins_raw[PIN_DIN]  = sdi_i;
    pins_raw[PIN_SELN] = sel_n_i;
    pins_raw[PIN_LDAC] = ldac_i;
    pins_raw[PIN_DIS]  = port_dis_i;
  end

  qdac_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PIN_RST;
    else        pins_q <= pins_s;
  end

  assign sclk_fall = pins_q[PIN_SCLK] & ~pins_s[PIN_SCLK];
  assign sel_fall  = pins_q[PIN_SELN] & ~pins_s[PIN_SELN];
  assign ldac_rise = ~pins_q[PIN_LDAC] & pins_s[PIN_LDAC];
  assign dis_s     = pins_s[PIN_DIS];

  qdac_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_fall(sclk_fall), .sel_fall(sel_fall),
    .sel_n_s(pins_s[PIN_SELN]), .din_s(pins_s[PIN_DIN]), .dis_s(dis_s),
    .cmd_valid_o(cmd_valid), .cmd_word_o(cmd_word)
  );

  qdac_reg_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .ldac_rise(ldac_rise),
    .dac_o(dac_regs_o), .ref_en_o(ref_en_o)
  );
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = VAL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [FRAME_W-1:0] cmd_word,
  input logic              ldac_rise,
  input logic              dis_s,
  input logic [NCH*DW-1:0] dac_regs,
  input logic              ref_en
);
  // R5
  dac_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_regs) |-> $past(cmd_valid || ldac_rise));
  // R8
  ref_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_en) |-> $past(cmd_valid && cmd_word[19]));
  // R9
  no_cmd_when_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !dis_s);
  // R4
  buf_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_word[19] && cmd_word[21:20] == 2'b00 && !ldac_rise)
      |=> $stable(dac_regs));
  // R8
  ref_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[19] && !ldac_rise) |=> $stable(dac_regs));
  // R7
  bcast_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_word[19] && cmd_word[21:20] == 2'b11)
      |=> dac_regs == {NCH{$past(cmd_word[DW-1:0])}});
endmodule

bind qdac_front qdac_front_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .ldac_rise(ldac_rise), .dis_s(dis_s), .dac_regs(dac_regs_o), .ref_en(ref_en_o)
);

// File: tb/qdac_front_tb_top.sv
module qdac_front_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sel_n = 1'b1, sdi = 1'b0, ldac = 1'b0, dis = 1'b0;
  logic [63:0] dac_regs;
  logic ref_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qdac_front dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .sdi_i(sdi),
    .ldac_i(ldac), .port_dis_i(dis), .dac_regs_o(dac_regs), .ref_en_o(ref_en)
  );

  // ---------------- behavioural reference model ----------------
  // bits: 0 sclk, 1 data, 2 select_n, 3 strobe, 4 disable
  logic [4:0] h1, h2, h3;
  bit m_act;
  int m_cnt;
  logic [23:0] m_word;
  logic [15:0] m_buf [4];
  logic [15:0] m_dac [4];
  bit m_ref;

  task automatic m_apply(input logic [23:0] w);
    int c;
    c = int'(w[18:17]);
    if (w[19]) m_ref = w[0];
    else case (w[21:20])
      2'b00: m_buf[c] = w[15:0];
      2'b01: begin m_buf[c] = w[15:0]; m_dac[c] = w[15:0]; end
      2'b10: begin m_buf[c] = w[15:0]; foreach (m_dac[i]) m_dac[i] = m_buf[i]; end
      default: foreach (m_dac[i]) begin m_buf[i] = w[15:0]; m_dac[i] = w[15:0]; end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 5'b10100; h2 = 5'b10100; h3 = 5'b10100;
      m_act = 0; m_cnt = 0; m_word = '0; m_ref = 1;
      foreach (m_buf[i]) begin m_buf[i] = '0; m_dac[i] = '0; end
    end else begin
      if (h2[4] || h2[2]) begin
        m_act = 0; m_cnt = 0; m_word = '0;
      end else if (h3[2] && !h2[2]) begin
        m_act = 1; m_cnt = 0; m_word = '0;
      end else if (m_act && h3[0] && !h2[0]) begin
        m_word = {m_word[22:0], h2[1]};
        m_cnt++;
        if (m_cnt == 24) begin
          m_apply(m_word);
          m_act = 0; m_cnt = 0; m_word = '0;
        end
      end
      if (!h3[3] && h2[3]) foreach (m_dac[i]) m_dac[i] = m_buf[i];
      h3 = h2; h2 = h1; h1 = {dis, ldac, sel_n, sdi, sclk};
    end
  end

  // compared on every clock, away from the active edge; commit timing is R1
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 4; i++) begin
        checks++;
        if (dac_regs[i*16 +: 16] !== m_dac[i]) begin
          errors++;
          $display("FAIL R1 model compare ch%0d actual %h expected %h", i, dac_regs[i*16 +: 16], m_dac[i]);
        end
      end
      checks++;
      if (ref_en !== m_ref) begin
        errors++;
        $display("FAIL R8 model compare ref actual %b expected %b", ref_en, m_ref);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  function automatic logic [23:0] mk(input logic [1:0] ld, input logic rf,
                                     input logic [1:0] ch, input logic [15:0] d);
    return {2'b00, ld, rf, ch, 1'b0, d};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w, input int nbits, input int extra);
    sel_n = 1'b0; tick(4);
    for (int i = 23; i > 23 - nbits; i--) begin
      sclk = 1'b1; sdi = w[i]; tick(4);
      sclk = 1'b0; tick(4);
    end
    for (int k = 0; k < extra; k++) begin
      sclk = 1'b1; sdi = 1'b1; tick(4);
      sclk = 1'b0; tick(4);
    end
    tick(2); sel_n = 1'b1; tick(8);
  endtask

  task automatic strobe();
    ldac = 1'b1; tick(4); ldac = 1'b0; tick(6);
  endtask

  task automatic expect_dac(input int ch, input logic [15:0] exp, input string req);
    checks++;
    if (dac_regs[ch*16 +: 16] !== exp) begin
      errors++;
      $display("FAIL %s ch%0d actual %h expected %h", req, ch, dac_regs[ch*16 +: 16], exp);
    end
  endtask

  task automatic expect_ref(input logic exp, input string req);
    checks++;
    if (ref_en !== exp) begin
      errors++;
      $display("FAIL %s ref actual %b expected %b", req, ref_en, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(4);
    // R10 reset state
    for (int i = 0; i < 4; i++) expect_dac(i, 16'h0000, "R10");
    expect_ref(1'b1, "R10");
    // R3 self load
    send(mk(2'b01, 1'b0, 2'd1, 16'h1234), 24, 0);
    expect_dac(1, 16'h1234, "R3");
    expect_dac(0, 16'h0000, "R3");
    // R4 buffer-only writes
    send(mk(2'b00, 1'b0, 2'd0, 16'hAAAA), 24, 0);
    send(mk(2'b00, 1'b0, 2'd3, 16'h5555), 24, 0);
    expect_dac(0, 16'h0000, "R4");
    expect_dac(3, 16'h0000, "R4");
    // R5 strobe
    strobe();
    expect_dac(0, 16'hAAAA, "R5");
    expect_dac(3, 16'h5555, "R5");
    expect_dac(1, 16'h1234, "R5");
    expect_dac(2, 16'h0000, "R5");
    // R6 update all from buffers
    send(mk(2'b00, 1'b0, 2'd0, 16'h1111), 24, 0);
    send(mk(2'b10, 1'b0, 2'd2, 16'h0F0F), 24, 0);
    expect_dac(0, 16'h1111, "R6");
    expect_dac(2, 16'h0F0F, "R6");
    expect_dac(3, 16'h5555, "R6");
    // R7 broadcast
    send(mk(2'b11, 1'b0, 2'd1, 16'h7777), 24, 0);
    for (int i = 0; i < 4; i++) expect_dac(i, 16'h7777, "R7");
    // R2 aborted frame, then strobe exposes buffers
    send(mk(2'b01, 1'b0, 2'd0, 16'h0000), 20, 0);
    expect_dac(0, 16'h7777, "R2");
    strobe();
    expect_dac(0, 16'h7777, "R2");
    // R8 reference command
    send(mk(2'b01, 1'b1, 2'd0, 16'hFFFE), 24, 0);
    expect_ref(1'b0, "R8");
    expect_dac(0, 16'h7777, "R8");
    strobe();
    expect_dac(0, 16'h7777, "R8");
    // R9 disabled port
    dis = 1'b1; tick(4);
    send(mk(2'b01, 1'b0, 2'd3, 16'h9999), 24, 0);
    dis = 1'b0; tick(4);
    expect_dac(3, 16'h7777, "R9");
    strobe();
    expect_dac(3, 16'h7777, "R9");
    // R1 extra clocks past the 24th edge are ignored
    send(mk(2'b01, 1'b0, 2'd1, 16'hCAFE), 24, 5);
    expect_dac(1, 16'hCAFE, "R1");
    expect_dac(2, 16'h7777, "R1");
    // R8 reference back on
    send(mk(2'b00, 1'b1, 2'd2, 16'h0001), 24, 0);
    expect_ref(1'b1, "R8");
    tick(10);
    finish_run();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        $display("FAIL watchdog actual %0d expected below 100000 cycles", cycles);
        finish_run();
      end
    end
  end
endmodule